// File: doc/BRIEF.md
# Stereo Quarter-dB Volume Stage with Raised-Cosine Soft Mute

This block scales a stereo stream of signed audio samples one sample at a time. A binary attenuation code selects the gain in quarter-decibel steps. The code is split into two parts. The whole number of 24-step groups gives an arithmetic right shift, about 6 dB per shift. The remainder indexes a 24-entry fine-gain table. A code past the top of the range selects full silence.

On top of the attenuation sits a soft mute. When mute is requested, the mute gain does not drop at once. It walks down a raised-cosine curve of 32 table points, and each point is held for 4 samples. The ramp therefore lasts 128 samples, about 3 ms at 44.1 kHz. Releasing the request walks the same curve back up to unity. A change of request in the middle of a ramp turns the walk around at the current point.

The ramp state moves only on sample-valid strobes. Both channels always use the same combined gain. The result appears one clock after the strobe, rounded and saturated to the sample width.

Top module: `stereo_softmute_vol`

## Requirements
- R1: For attenuation codes 0 to 263, each output equals round-half-up((x * G) / 2^(15 + code/24)), where G = round-half-up(F * M / 2^15). F = round(32768 * 10^(-(code mod 24)/80)) is the fine gain. M is the current mute gain from R3 (32768 when not muted).
- R2: Any attenuation code of 264 or above forces both outputs to zero.
- R3: The ramp position runs from 0 (unity) to 128 (silent). While mute is requested, each sample strobe raises it by one. The mute gain at position p is round(32768 * cos²(π·(p/4)/64)), where p/4 is integer division, so each of the 33 levels is held for 4 samples.
- R4: mute_done is high exactly when the ramp position is 128. This takes 128 strobes with mute requested, starting from unity.
- R5: While mute is not requested, each sample strobe lowers the position by one until it reaches 0. Unity gain returns after 128 strobes.
- R6: A change of mute request in mid-ramp continues from the current position. The position never moves by more than one per strobe.
- R7: out_valid is in_valid delayed by one clock. Without a strobe, the outputs, the ramp position and mute_done keep their values.
- R8: Left and right use the same gain, so equal inputs give equal outputs.
- R9: Results are saturated to the signed 16-bit range. Full-scale inputs of either sign at code 0 pass unchanged.
- R10: After reset, out_valid, mute_done and both outputs are 0, and the ramp starts at unity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe for both channels |
| in_left | input | 16 | Left input sample, signed |
| in_right | input | 16 | Right input sample, signed |
| att_code | input | 9 | Attenuation in 0.25 dB steps; 264 and above selects silence |
| mute_req | input | 1 | Soft mute request |
| out_valid | output | 1 | Output strobe, one clock after in_valid |
| out_left | output | 16 | Scaled left sample, signed |
| out_right | output | 16 | Scaled right sample, signed |
| mute_done | output | 1 | Ramp has reached silence |

## Verification
A ramp position that is off by even one step changes the mute gain at the next level boundary. That is at most four strobes later, and it shows up as a wrong output on every nonzero sample after that. mute_done would also rise on the wrong strobe. An error in the fine table or in the shift decode is visible on the very next strobe at the affected code. Random codes and large samples reach it within a few hundred strobes. A position that moves without a strobe is caught at the next strobe, because the expected gain at that point is known.

// File: rtl/vol_pkg.sv
package vol_pkg;
  localparam int DATA_W      = 16;
  localparam int CODE_W      = 9;
  localparam int FRAC_W      = 15;
  localparam int GAIN_W      = FRAC_W + 2;
  localparam int STEPS_PER_SH = 24;
  localparam int CODE_LIMIT  = 264;
  localparam int RAMP_POINTS = 32;
  localparam int RAMP_HOLD   = 4;
  localparam int RAMP_LEN    = RAMP_POINTS * RAMP_HOLD;
  localparam int POS_W       = $clog2(RAMP_LEN + 1);
  localparam int SH_W        = $clog2(CODE_LIMIT / STEPS_PER_SH + 1);

  // Fine gain for a quarter-dB remainder, Q1.15
  function automatic logic [GAIN_W-1:0] fine_point(input int k);
    real v;
    v = $exp(-$ln(10.0) * real'(k) / 80.0);
    return GAIN_W'($rtoi(v * 32768.0 + 0.5));
  endfunction

  // Raised-cosine mute level k of RAMP_POINTS, Q1.15
  function automatic logic [GAIN_W-1:0] ramp_point(input int k);
    real v;
    v = 0.5 * (1.0 + $cos(3.141592653589793 * real'(k) / real'(RAMP_POINTS)));
    return GAIN_W'($rtoi(v * 32768.0 + 0.5));
  endfunction

  // Combined gain: round(fine * ramp / 2^15)
  function automatic logic [GAIN_W-1:0] merge_gain(input logic [GAIN_W-1:0] f,
                                                    input logic [GAIN_W-1:0] r);
    logic [2*GAIN_W-1:0] p;
    p = f * r + (2*GAIN_W)'(1 << (FRAC_W - 1));
    return GAIN_W'(p >> FRAC_W);
  endfunction
endpackage

// File: rtl/vol_gain_rom.sv
module vol_gain_rom
  import vol_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [GAIN_W-1:0] fine,
  output logic [SH_W-1:0]   shift,
  output logic              silent
);
  logic [GAIN_W-1:0] table_q [STEPS_PER_SH];

  for (genvar k = 0; k < STEPS_PER_SH; k++) begin : g_fine
    localparam logic [GAIN_W-1:0] PT = fine_point(k);
    assign table_q[k] = PT;
  end

  logic [CODE_W-1:0] quot, rem;
  assign quot   = code / CODE_W'(STEPS_PER_SH);
  assign rem    = code % CODE_W'(STEPS_PER_SH);
  assign silent = (code >= CODE_W'(CODE_LIMIT));
  assign shift  = silent ? '0 : SH_W'(quot);
  assign fine   = table_q[rem[$clog2(STEPS_PER_SH)-1:0]];
endmodule

// File: rtl/vol_ramp_ctrl.sv
module vol_ramp_ctrl
  import vol_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              mute_req,
  output logic [GAIN_W-1:0] ramp_gain,
  output logic              at_floor
);
  localparam int LVL_W = $clog2(RAMP_POINTS + 1);

  logic [GAIN_W-1:0] curve [RAMP_POINTS + 1];
  for (genvar k = 0; k <= RAMP_POINTS; k++) begin : g_curve
    localparam logic [GAIN_W-1:0] PT = ramp_point(k);
    assign curve[k] = PT;
  end

  logic [POS_W-1:0] pos_q;
  logic             step_down_gain, step_up_gain;
  logic [LVL_W-1:0] level;

  assign step_down_gain = in_valid && mute_req && (pos_q != POS_W'(RAMP_LEN));
  assign step_up_gain   = in_valid && !mute_req && (pos_q != '0);
  assign level          = LVL_W'(pos_q / POS_W'(RAMP_HOLD));
  assign ramp_gain      = curve[level];
  assign at_floor       = (pos_q == POS_W'(RAMP_LEN));

  always_ff @(posedge clk) begin
    if (!rst_n)              pos_q <= '0;
    else if (step_down_gain) pos_q <= pos_q + 1'b1;
    else if (step_up_gain)   pos_q <= pos_q - 1'b1;
  end

  // R3
  pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_W'(RAMP_LEN));
  // R6
  pos_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (pos_q == $past(pos_q) + 1'b1) || (pos_q == $past(pos_q) - 1'b1)
                 || (pos_q == $past(pos_q)));
  // R7
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(pos_q));
  // R4
  floor_needs_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(at_floor) |-> $past(mute_req) && $past(in_valid));
endmodule

// File: rtl/vol_scale.sv
module vol_scale
  import vol_pkg::*;
(
  input  logic signed [DATA_W-1:0] x,
  input  logic        [GAIN_W-1:0] gain,
  input  logic        [SH_W-1:0]   shift,
  input  logic                     silent,
  output logic signed [DATA_W-1:0] y
);
  localparam int PROD_W = DATA_W + GAIN_W + 2;
  localparam logic signed [PROD_W-1:0] MAXV = PROD_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] MINV = -PROD_W'(1 << (DATA_W - 1));

  logic signed [PROD_W-1:0] prod, rounded, shifted;
  logic [5:0] total_sh;

  assign total_sh = 6'(FRAC_W) + 6'(shift);
  assign prod     = PROD_W'(x) * $signed({1'b0, gain});
  assign rounded  = prod + (PROD_W'(1) <<< (total_sh - 6'd1));
  assign shifted  = rounded >>> total_sh;

  always_comb begin
    if (silent)              y = '0;
    else if (shifted > MAXV) y = MAXV[DATA_W-1:0];
    else if (shifted < MINV) y = MINV[DATA_W-1:0];
    else                     y = shifted[DATA_W-1:0];
  end
endmodule

// File: rtl/stereo_softmute_vol.sv
module stereo_softmute_vol
  import vol_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [15:0]       in_left,
  input  logic [15:0]       in_right,
  input  logic [8:0]        att_code,
  input  logic              mute_req,
  output logic              out_valid,
  output logic [15:0]       out_left,
  output logic [15:0]       out_right,
  output logic              mute_done
);
  logic [GAIN_W-1:0] fine, ramp_gain, total_gain;
  logic [SH_W-1:0]   shift;
  logic              silent;

  vol_gain_rom u_rom (.code(att_code), .fine(fine), .shift(shift), .silent(silent));

  vol_ramp_ctrl u_ramp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mute_req(mute_req),
    .ramp_gain(ramp_gain), .at_floor(mute_done)
  );

  assign total_gain = merge_gain(fine, ramp_gain);

  logic [DATA_W-1:0] chan_in  [2];
  logic [DATA_W-1:0] chan_out [2];
  logic [DATA_W-1:0] chan_q   [2];
  assign chan_in[0] = in_left;
  assign chan_in[1] = in_right;

  for (genvar c = 0; c < 2; c++) begin : g_chan
    vol_scale u_scale (
      .x(chan_in[c]), .gain(total_gain), .shift(shift), .silent(silent),
      .y(chan_out[c])
    );
    always_ff @(posedge clk) begin
      if (!rst_n)        chan_q[c] <= '0;
      else if (in_valid) chan_q[c] <= chan_out[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  assign out_left  = chan_q[0];
  assign out_right = chan_q[1];

  // R7
  strobe_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));
  // R2
  silent_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && att_code >= 9'(CODE_LIMIT)) |=> (out_left == '0 && out_right == '0));
  // R8
  stereo_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_left == in_right) |=> (out_left == out_right));
  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_left) && $stable(out_right));
endmodule

// File: tb/tb_stereo_softmute_vol.sv
module tb_stereo_softmute_vol;
  logic clk = 0, rst_n = 0, in_valid = 0, mute_req = 0;
  logic [15:0] in_left = 0, in_right = 0;
  logic [8:0]  att_code = 0;
  logic        out_valid, mute_done;
  logic [15:0] out_left, out_right;

  int checks = 0, errors = 0, mpos = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  stereo_softmute_vol dut (.*);

  function automatic longint fine_ref(int code);
    return longint'($rtoi($pow(10.0, -real'(code % 24) / 80.0) * 32768.0 + 0.5));
  endfunction

  function automatic longint mute_ref(int p);
    real c;
    c = $cos(3.141592653589793 * real'(p / 4) / 64.0);
    return longint'($rtoi(c * c * 32768.0 + 0.5));
  endfunction

  function automatic int expect_out(int x, int code, int p);
    longint g, v;
    int s;
    if (code >= 264) return 0;
    g = (fine_ref(code) * mute_ref(p) + 16384) / 32768;
    s = 15 + code / 24;
    v = (longint'(x) * g + (longint'(1) <<< (s - 1))) >>> s;
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return int'(v);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one strobe: drive at negedge, check at following negedge
  task automatic send(int l, int r, int code, bit m, string req);
    int el, er;
    el = expect_out(l, code, mpos);
    er = expect_out(r, code, mpos);
    in_valid = 1; in_left = 16'(l); in_right = 16'(r);
    att_code = 9'(code); mute_req = m;
    if (m && mpos < 128) mpos++;
    else if (!m && mpos > 0) mpos--;
    @(negedge clk);
    in_valid = 0;
    check({req, " left"}, int'($signed(out_left)), el);
    check({req, " right"}, int'($signed(out_right)), er);
    check("R7 out_valid", int'(out_valid), 1);
    check("R4 mute_done", int'(mute_done), int'(mpos == 128));
  endtask

  task automatic idle_check(int cyc);
    logic [15:0] hl, hr;
    hl = out_left; hr = out_right;
    mute_req = ~mute_req;
    repeat (cyc) @(negedge clk);
    check("R7 idle valid", int'(out_valid), 0);
    check("R7 idle hold", int'(out_left == hl && out_right == hr), 1);
    check("R7 idle done", int'(mute_done), int'(mpos == 128));
  endtask

  function automatic int rsamp();
    return int'($signed(16'($urandom)));
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 valid", int'(out_valid), 0);
    check("R10 left", int'(out_left), 0);
    check("R10 done", int'(mute_done), 0);

    // R9 full scale at code 0
    send(32767, -32768, 0, 0, "R9");
    send(-32768, 32767, 0, 0, "R9");
    // R1 edge codes
    send(20000, -20000, 263, 0, "R1");
    send(1, -1, 23, 0, "R1");
    send(12345, 12345, 24, 0, "R8");
    // R2 silence codes
    send(30000, -30000, 264, 0, "R2");
    send(30000, -30000, 511, 0, "R2");
    // R1 random codes
    for (int i = 0; i < 300; i++) begin
      int v;
      v = rsamp();
      send(rsamp(), (i % 5 == 0) ? v : rsamp(), int'($urandom_range(0, 300)), 0,
           (i % 5 == 0) ? "R8" : "R1");
    end
    // R3/R4 full mute ramp, with idle gaps
    for (int i = 0; i < 140; i++) begin
      send(rsamp(), rsamp(), int'($urandom_range(0, 40)), 1, "R3");
      if (i % 37 == 0) begin mute_req = 1; idle_check(3); end
    end
    // R5 release back to unity
    for (int i = 0; i < 135; i++) send(30000, -30000, 0, 0, "R5");
    // R6 reversal in mid-ramp
    for (int i = 0; i < 50; i++) send(rsamp(), rsamp(), 5, 1, "R6");
    for (int i = 0; i < 20; i++) send(rsamp(), rsamp(), 5, 0, "R6");
    for (int i = 0; i < 9; i++)  send(rsamp(), rsamp(), 5, 1, "R6");
    // mixed random
    for (int i = 0; i < 600; i++) begin
      send(rsamp(), rsamp(), int'($urandom_range(0, 280)), bit'($urandom_range(0, 9) < 6), "R6");
      if ($urandom_range(0, 15) == 0) idle_check(int'($urandom_range(1, 4)));
    end
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule